// File: doc/BRIEF.md
# 8-bit ALU with Decimal Adjust

This block is the purely combinational arithmetic and logic stage of an accumulator-based 8-bit microcontroller datapath. Each evaluation takes the current accumulator byte, a second operand byte, the incoming carry and auxiliary-carry flags, and a 4-bit operation code. It returns the result byte and the next values of the carry, auxiliary-carry and overflow flags.

Each of the three flags has its own write enable. The surrounding flag register loads only the flags the operation actually defines. When an enable is low, the matching flag output simply repeats the incoming value; overflow, which has no input, reads as 0.

The operations are:
- add, add with carry and subtract with borrow;
- increment and decrement;
- bitwise AND, OR, XOR and complement;
- rotates left and right, plain and through the carry;
- nibble exchange;
- packed-BCD correction after an addition.

The block holds no state and has no clock or reset.

Top module: `alu8_core`

## Requirements
- R11: Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 AND, 6 OR, 7 XOR, 8 complement, 9 rotate left, 10 rotate left through carry, 11 rotate right, 12 rotate right through carry, 13 nibble swap, 14 decimal adjust, 15 pass the accumulator unchanged with no flag enables.
- R1: Add (code 0) returns the low byte of acc+src and ignores the incoming carry. Carry out is the carry from bit 7 and AC is the carry from bit 3; both are cleared otherwise. C3h+AAh gives 6Dh with C=1, AC=0, OV=1.
- R2: Add with carry (code 1) adds the incoming carry as a third addend, with flags as in R1. C3h+AAh+1 gives 6Eh with C=1, AC=0, OV=1.
- R3: Subtract with borrow (code 2) returns acc−src−C. C is set on a borrow out of bit 7 and AC on a borrow out of bit 3. C9h−54h−1 gives 74h with C=0, AC=0, OV=1.
- R4: For codes 0–2, OV is the XOR of the carry (or borrow) out of bit 6 and the one out of bit 7. It therefore flags a signed result outside −128..127.
- R5: Increment wraps FFh to 00h and decrement wraps 00h to FFh. Neither raises any flag enable.
- R6: AND, OR, XOR, complement and nibble swap raise no flag enable. Examples: C3h AND 55h = 41h, C3h OR 55h = D7h, C3h XOR AAh = 69h, complement of 5Ch = A3h, swap of C5h = 5Ch.
- R7: Plain rotate left moves bit 7 into bit 0 (C5h gives 8Bh). Plain rotate right moves bit 0 into bit 7 (C5h gives E2h). Neither raises a flag enable.
- R8: Rotate left through carry puts bit 7 into C and the old C into bit 0; C5h with C=0 gives 8Ah with C=1. Rotate right through carry puts bit 0 into C and the old C into bit 7; C5h with C=0 gives 62h with C=1. Only the C enable is raised.
- R9: Decimal adjust first adds 06h when the low nibble exceeds 9 or AC=1. It then adds 60h when C (including a carry from the first step) is 1 or the new high nibble exceeds 9. Either step may set C but never clears it, and only the C enable is raised.
- R10: Codes 0–2 raise all three enables. Whenever an enable is low, `cy_o`=`cy_i`, `ac_o`=`ac_i` and `ov_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| op_i | input | 4 | Operation code (see R11) |
| res_o | output | 8 | Result byte |
| cy_o | output | 1 | Next carry flag |
| ac_o | output | 1 | Next auxiliary-carry flag |
| ov_o | output | 1 | Next overflow flag |
| cy_we_o | output | 1 | Carry update enable |
| ac_we_o | output | 1 | Auxiliary-carry update enable |
| ov_we_o | output | 1 | Overflow update enable |

## Verification
The bench goes after the points where the flag rules are easy to get wrong:
- Overflow on additions that carry out of bit 6 but not bit 7, and on subtractions that borrow into bit 6 only. A design that took OV from the sign of the result alone would miss these.
- A plain add with a stale carry set, which catches an adder that leaks `cy_i` into the sum.
- Decimal adjust with an incoming carry that no step regenerates, and with a first-step carry out of the whole byte. A wrong design would clear C in the first case or skip the 60h correction in the second.
- Wrapping increment and decrement, and the logic ops, where any raised enable would corrupt a flag the program relies on.
- Sweeps of add and subtract, compared against a signed-range overflow model rather than a carry-based one.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NIB = 4;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RLC  = 4'd10,
        OP_RR   = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWAP = 4'd13,
        OP_DA   = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cy;
        logic          ac;
        logic          ov;
        logic          cy_we;
        logic          ac_we;
        logic          ov_we;
    } alu_out_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

    function automatic logic uses_adder(alu_op_e op);
        return is_arith(op) || (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_nib,
    output logic         c_pre,
    output logic         c_top
);
    logic [N:0] lo;
    logic [W-1:0] mid;
    logic [W:0] full;

    // Carries (add) or borrows (subtract) at the nibble boundary, into the
    // sign bit, and out of the word come from three parallel partial sums.
    always_comb begin
        if (sub) begin
            lo   = {1'b0, a[N-1:0]} - {1'b0, b[N-1:0]} - {{N{1'b0}}, cin};
            mid  = {1'b0, a[W-2:0]} - {1'b0, b[W-2:0]} - {{(W-1){1'b0}}, cin};
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            lo   = {1'b0, a[N-1:0]} + {1'b0, b[N-1:0]} + {{N{1'b0}}, cin};
            mid  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin};
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
    end

    assign sum   = full[W-1:0];
    assign c_nib = lo[N];
    assign c_pre = mid[W-1];
    assign c_top = full[W];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cy_new,
    output logic          cy_we
);
    localparam int HALF = DW / 2;

    always_comb begin
        res    = a;
        cy_new = cin;
        cy_we  = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_RLC: begin
                res    = {a[DW-2:0], cin};
                cy_new = a[DW-1];
                cy_we  = 1'b1;
            end
            OP_RRC: begin
                res    = {cin, a[DW-1:1]};
                cy_new = a[0];
                cy_we  = 1'b1;
            end
            OP_SWAP: res = {a[HALF-1:0], a[DW-1:HALF]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_bcd_adj.sv
module alu8_bcd_adj #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [W-1:0] a,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam int DIGITS = W / N;

    logic [W-1:0] val [DIGITS+1];
    logic         cyc [DIGITS+1];

    assign val[0] = a;
    assign cyc[0] = cy_in;

    // One correction stage per digit, lowest first; the carry is sticky.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        localparam logic [W:0] ADJ = (W+1)'(6) << (N * d);
        logic         trig;
        logic [W:0]   sum;
        logic         flag;

        assign flag = (d == 0) ? ac_in : cyc[d];
        assign trig = (val[d][N*d +: N] > N'(9)) || flag;
        assign sum  = {1'b0, val[d]} + ADJ;
        assign val[d+1] = trig ? sum[W-1:0] : val[d];
        assign cyc[d+1] = cyc[d] | (trig & sum[W]);
    end

    assign res    = val[DIGITS];
    assign cy_out = cyc[DIGITS];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  src_i,
    input  logic           cy_i,
    input  logic           ac_i,
    input  logic [OPW-1:0] op_i,
    output logic [DW-1:0]  res_o,
    output logic           cy_o,
    output logic           ac_o,
    output logic           ov_o,
    output logic           cy_we_o,
    output logic           ac_we_o,
    output logic           ov_we_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // shared adder/subtractor operand steering
    logic [DW-1:0] as_b, as_sum;
    logic          as_cin, as_sub;
    logic          c_nib, c_pre, c_top;

    always_comb begin
        as_b   = src_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADDC: as_cin = cy_i;
            OP_SUBB: begin as_cin = cy_i; as_sub = 1'b1; end
            OP_INC:  as_b = DW'(1);
            OP_DEC:  begin as_b = DW'(1); as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW), .N(NIB)) u_addsub (
        .a    (acc_i),
        .b    (as_b),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .c_nib(c_nib),
        .c_pre(c_pre),
        .c_top(c_top)
    );

    logic [DW-1:0] bo_res;
    logic          bo_cy, bo_we;

    alu8_bitops u_bitops (
        .op    (op),
        .a     (acc_i),
        .b     (src_i),
        .cin   (cy_i),
        .res   (bo_res),
        .cy_new(bo_cy),
        .cy_we (bo_we)
    );

    logic [DW-1:0] da_res;
    logic          da_cy;

    alu8_bcd_adj #(.W(DW), .N(NIB)) u_bcd (
        .a     (acc_i),
        .cy_in (cy_i),
        .ac_in (ac_i),
        .res   (da_res),
        .cy_out(da_cy)
    );

    alu_out_t o;

    always_comb begin
        o     = '0;
        o.res = acc_i;
        if (is_arith(op)) begin
            o.res   = as_sum;
            o.cy    = c_top;
            o.ac    = c_nib;
            o.ov    = c_pre ^ c_top;
            o.cy_we = 1'b1;
            o.ac_we = 1'b1;
            o.ov_we = 1'b1;
        end else if (uses_adder(op)) begin
            o.res = as_sum;
        end else if (op == OP_DA) begin
            o.res   = da_res;
            o.cy    = da_cy;
            o.cy_we = 1'b1;
        end else if (op != OP_PASS) begin
            o.res   = bo_res;
            o.cy    = bo_cy;
            o.cy_we = bo_we;
        end
    end

    assign res_o   = o.res;
    assign cy_o    = o.cy_we ? o.cy : cy_i;
    assign ac_o    = o.ac_we ? o.ac : ac_i;
    assign ov_o    = o.ov_we ? o.ov : 1'b0;
    assign cy_we_o = o.cy_we;
    assign ac_we_o = o.ac_we;
    assign ov_we_o = o.ov_we;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [DW-1:0]  acc_i,
    input logic [DW-1:0]  src_i,
    input logic           cy_i,
    input logic           ac_i,
    input logic [OPW-1:0] op_i,
    input logic [DW-1:0]  res_o,
    input logic           cy_o,
    input logic           ac_o,
    input logic           ov_o,
    input logic           cy_we_o,
    input logic           ac_we_o,
    input logic           ov_we_o
);
    always_comb begin
        if (op_i <= 4'd2) begin
            assert_arith_enables_R10: assert (cy_we_o && ac_we_o && ov_we_o)
                else $error("arith op without full flag enables");
        end
        if (op_i == 4'd3) begin
            assert_inc_wrap_R5: assert (res_o == acc_i + 8'd1 && !cy_we_o && !ac_we_o && !ov_we_o)
                else $error("increment result or enable wrong");
        end
        if (op_i == 4'd4) begin
            assert_dec_wrap_R5: assert (res_o == acc_i - 8'd1 && !cy_we_o && !ac_we_o && !ov_we_o)
                else $error("decrement result or enable wrong");
        end
        if (op_i >= 4'd5 && op_i <= 4'd8) begin
            assert_logic_noflag_R6: assert (!cy_we_o && !ac_we_o && !ov_we_o && cy_o == cy_i && ac_o == ac_i)
                else $error("logic op touched a flag");
        end
        if (op_i == 4'd10) begin
            assert_rlc_carry_R8: assert (cy_o == acc_i[7] && res_o[0] == cy_i && cy_we_o)
                else $error("rotate-left-through-carry wrong");
        end
        if (op_i == 4'd12) begin
            assert_rrc_carry_R8: assert (cy_o == acc_i[0] && res_o[7] == cy_i && cy_we_o)
                else $error("rotate-right-through-carry wrong");
        end
        if (op_i == 4'd14 && cy_i) begin
            assert_da_sticky_R9: assert (cy_o)
                else $error("decimal adjust cleared carry");
        end
        if (!ov_we_o) begin
            assert_ov_idle_R10: assert (!ov_o)
                else $error("overflow output set without enable");
        end
    end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] acc_i, src_i, res_o;
    logic [3:0] op_i;
    logic cy_i, ac_i, cy_o, ac_o, ov_o, cy_we_o, ac_we_o, ov_we_o;

    alu8_core u0 (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // {op, acc, src, cy, ac, res, cy_o, ac_o, ov_o, we(cy,ac,ov)}
    localparam int NV = 31;
    localparam logic [35:0] VEC [NV] = '{
        {4'd0, 8'hC3,8'hAA,1'b0,1'b0, 8'h6D,1'b1,1'b0,1'b1,3'b111},
        {4'd0, 8'hC3,8'hAA,1'b1,1'b1, 8'h6D,1'b1,1'b0,1'b1,3'b111},
        {4'd0, 8'h08,8'h08,1'b0,1'b0, 8'h10,1'b0,1'b1,1'b0,3'b111},
        {4'd0, 8'h40,8'h40,1'b0,1'b0, 8'h80,1'b0,1'b0,1'b1,3'b111},
        {4'd1, 8'hC3,8'hAA,1'b1,1'b0, 8'h6E,1'b1,1'b0,1'b1,3'b111},
        {4'd1, 8'hFF,8'h00,1'b1,1'b0, 8'h00,1'b1,1'b1,1'b0,3'b111},
        {4'd2, 8'hC9,8'h54,1'b1,1'b0, 8'h74,1'b0,1'b0,1'b1,3'b111},
        {4'd2, 8'h00,8'h01,1'b0,1'b0, 8'hFF,1'b1,1'b1,1'b0,3'b111},
        {4'd2, 8'h80,8'h01,1'b0,1'b0, 8'h7F,1'b0,1'b1,1'b1,3'b111},
        {4'd3, 8'hFF,8'h00,1'b1,1'b0, 8'h00,1'b1,1'b0,1'b0,3'b000},
        {4'd3, 8'h7E,8'h00,1'b0,1'b1, 8'h7F,1'b0,1'b1,1'b0,3'b000},
        {4'd4, 8'h00,8'h00,1'b0,1'b1, 8'hFF,1'b0,1'b1,1'b0,3'b000},
        {4'd4, 8'h80,8'h00,1'b1,1'b1, 8'h7F,1'b1,1'b1,1'b0,3'b000},
        {4'd5, 8'hC3,8'h55,1'b1,1'b1, 8'h41,1'b1,1'b1,1'b0,3'b000},
        {4'd6, 8'hC3,8'h55,1'b0,1'b0, 8'hD7,1'b0,1'b0,1'b0,3'b000},
        {4'd7, 8'hC3,8'hAA,1'b1,1'b0, 8'h69,1'b1,1'b0,1'b0,3'b000},
        {4'd8, 8'h5C,8'h00,1'b0,1'b1, 8'hA3,1'b0,1'b1,1'b0,3'b000},
        {4'd9, 8'hC5,8'h00,1'b0,1'b0, 8'h8B,1'b0,1'b0,1'b0,3'b000},
        {4'd10,8'hC5,8'h00,1'b0,1'b0, 8'h8A,1'b1,1'b0,1'b0,3'b100},
        {4'd10,8'h01,8'h00,1'b1,1'b1, 8'h03,1'b0,1'b1,1'b0,3'b100},
        {4'd11,8'hC5,8'h00,1'b1,1'b0, 8'hE2,1'b1,1'b0,1'b0,3'b000},
        {4'd12,8'hC5,8'h00,1'b0,1'b0, 8'h62,1'b1,1'b0,1'b0,3'b100},
        {4'd12,8'h02,8'h00,1'b1,1'b0, 8'h81,1'b0,1'b0,1'b0,3'b100},
        {4'd13,8'hC5,8'h00,1'b0,1'b0, 8'h5C,1'b0,1'b0,1'b0,3'b000},
        {4'd14,8'hBD,8'h00,1'b0,1'b0, 8'h23,1'b1,1'b0,1'b0,3'b100},
        {4'd14,8'h99,8'h00,1'b1,1'b0, 8'hF9,1'b1,1'b0,1'b0,3'b100},
        {4'd14,8'hFA,8'h00,1'b0,1'b0, 8'h60,1'b1,1'b0,1'b0,3'b100},
        {4'd14,8'h3A,8'h00,1'b0,1'b0, 8'h40,1'b0,1'b0,1'b0,3'b100},
        {4'd14,8'h02,8'h00,1'b0,1'b1, 8'h08,1'b0,1'b1,1'b0,3'b100},
        {4'd14,8'h9A,8'h00,1'b0,1'b0, 8'h00,1'b1,1'b0,1'b0,3'b100},
        {4'd15,8'h5A,8'h33,1'b1,1'b1, 8'h5A,1'b1,1'b1,1'b0,3'b000}
    };

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0:          return "R1 R4 R10 R11";
            4'd1:          return "R2 R4 R10";
            4'd2:          return "R3 R4 R10";
            4'd3, 4'd4:    return "R5";
            4'd9, 4'd11:   return "R7";
            4'd10, 4'd12:  return "R8";
            4'd14:         return "R9";
            4'd15:         return "R11";
            default:       return "R6";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic h);
        @(posedge clk);
        #0.5;
        op_i = op; acc_i = a; src_i = b; cy_i = c; ac_i = h;
        #1.5;
    endtask

    task automatic check(input string tag, input logic [13:0] exp);
        logic [13:0] got;
        got = {res_o, cy_o, ac_o, ov_o, cy_we_o, ac_we_o, ov_we_o};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d acc=%h src=%h: got %h expected %h",
                     tag, op_i, acc_i, src_i, got, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // idle state: all-zero inputs decode as add of zeros (R1)
        drive(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
        check("R1 idle", {8'h00, 3'b000, 3'b111});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15], VEC[i][14]);
            check(tag_of(VEC[i][35:32]), VEC[i][13:0]);
        end

        // sweeps against a signed-range overflow model (R1 R3 R4)
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 8; k++) begin
                int b, c, s, ss, sa, sb;
                logic [13:0] e;
                b  = (k * 37 + a * 3) & 255;
                c  = (a + k) & 1;
                sa = (a > 127) ? a - 256 : a;
                sb = (b > 127) ? b - 256 : b;
                drive(4'd0, 8'(a), 8'(b), 1'(c), 1'b0);
                s  = a + b;
                ss = sa + sb;
                e  = {8'(s), 1'(s > 255), 1'(((a & 15) + (b & 15)) > 15),
                      1'(ss > 127 || ss < -128), 3'b111};
                check("R1 R4 sweep", e);
                drive(4'd2, 8'(a), 8'(b), 1'(c), 1'b1);
                s  = a - b - c;
                ss = sa - sb - c;
                e  = {8'(s), 1'(s < 0), 1'(((a & 15) - (b & 15) - c) < 0),
                      1'(ss > 127 || ss < -128), 3'b111};
                check("R3 R4 sweep", e);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule